// File: doc/BRIEF.md
# ADC Test Data Source Selector

This block decides what the receiver channels see on their internal ADC bus. In normal operation the live samples from the external converter pass straight through. For self test, software can swap them for one of two generated sources. One is a constant holding the most negative two's complement code. The other is a maximal-length pseudo-random sequence. Filter designs and whole channels can then be checked against a known stimulus without an analog source.

The block also drives the internal input-enable line. Normally this line follows the external enable pin. A separate control bit can make the test data behave like a time-multiplexed dual converter. In that case input-enable toggles on every clock, as an A/B channel select would, so the four-input channel mode can be exercised with internal data.

The control inputs are plain level bits taken from the software-sync register and the pin-sync register. The selection itself is combinational. Only the pseudo-random generator and the A/B phase are held in registers.

Top module: `adc_test_src`

## Requirements
- R1: With `test_en_i` low, `data_o` equals `adc_data_i` in the same cycle, whatever the other mode bits are.
- R2: With `test_en_i` high and `prn_sel_i` low, `data_o` holds the most negative code of the width: MSB set, all other bits clear (0x2000 at the default width of 14).
- R3: With `test_en_i` and `prn_sel_i` both high, `data_o` shows the generator state. The generator shifts left by one bit on every clock edge out of reset, whatever the mode. The new LSB is the XOR of the state bits picked by the tap mask (bits 13, 4, 2 and 0 at width 14).
- R4: The generator never reaches zero. After 2^W-1 steps from reset it returns to its seed.
- R5: When multiplex emulation is inactive (`test_en_i` low or `ab_emul_i` low), `en_o` equals `en_i` in the same cycle.
- R6: While `test_en_i` and `ab_emul_i` are both high, `en_o` inverts on every clock cycle.
- R7: In the first cycle of multiplex emulation, `en_o` is 1. This holds both after reset and on any re-entry after the mode was left.
- R8: While `rst_ni` is low, the generator holds its all-ones seed and the A/B phase is 1. The first cycle after reset therefore shows all ones in PRN mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_data_i | input | W | Live sample from the external converter |
| en_i | input | 1 | External input-enable pin |
| test_en_i | input | 1 | Selects internal test data instead of live data |
| prn_sel_i | input | 1 | In test mode: 1 selects the PRN sequence, 0 selects negative full scale |
| ab_emul_i | input | 1 | In test mode: toggles input-enable as a dual-converter A/B select |
| data_o | output | W | Word driven onto the internal ADC bus |
| en_o | output | 1 | Internal input-enable |

## Verification
The bench goes after the A/B phase at the edges of emulation mode. A design that does not restart the phase on re-entry opens with 0 half the time. A design that gates emulation on the pin-sync bit alone moves `en_o` away from the pin while test mode is off. The generator runs through a full period. A wrong tap mask shows up as a mismatch against the model within a few steps, and as a failure to return to the seed after 2^W-1 clocks. A generator that pauses outside PRN mode is caught when PRN mode is reselected. Mode bits change on cycles where live data differs from both generated sources, so a swapped or mis-decoded select shows on the bus at once.

// File: rtl/adc_test_src_pkg.sv
package adc_test_src_pkg;

  // Feedback masks for shift-left Fibonacci LFSRs of maximal length
  function automatic logic [31:0] prn_tap_mask(input int w);
    case (w)
      4:  return 32'h0000_000C;
      5:  return 32'h0000_0014;
      6:  return 32'h0000_0030;
      7:  return 32'h0000_0060;
      8:  return 32'h0000_00B8;
      9:  return 32'h0000_0110;
      10: return 32'h0000_0240;
      11: return 32'h0000_0500;
      12: return 32'h0000_0829;
      13: return 32'h0000_100D;
      14: return 32'h0000_2015;
      15: return 32'h0000_6000;
      16: return 32'h0000_D008;
      32: return 32'h8020_0003;
      default: return 32'h0000_000C;
    endcase
  endfunction

  typedef enum logic [1:0] {
    SRC_LIVE = 2'd0,
    SRC_NFS  = 2'd1,
    SRC_PRN  = 2'd2
  } src_sel_e;

endpackage

// File: rtl/adc_test_src_prn.sv
module adc_test_src_prn #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] prn_o
);
  localparam logic [W-1:0] TAPS = W'(adc_test_src_pkg::prn_tap_mask(W));
  localparam logic [W-1:0] SEED = {W{1'b1}};

  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[W-2:0], fb};
  end

  assign prn_o = state_q;
endmodule

// File: rtl/adc_test_src_abgen.sv
module adc_test_src_abgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emul_i,
  output logic phase_o
);
  logic phase_q;

  // phase sits at 1 while idle so entry always opens with 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b1;
    else if (emul_i) phase_q <= ~phase_q;
    else             phase_q <= 1'b1;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/adc_test_src_mux.sv
module adc_test_src_mux
  import adc_test_src_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         test_en_i,
  input  logic         prn_sel_i,
  input  logic [W-1:0] adc_data_i,
  input  logic [W-1:0] prn_i,
  output logic [W-1:0] data_o
);
  localparam logic [W-1:0] NEG_FS = {1'b1, {(W-1){1'b0}}};

  src_sel_e sel;

  always_comb begin
    if (!test_en_i)     sel = SRC_LIVE;
    else if (prn_sel_i) sel = SRC_PRN;
    else                sel = SRC_NFS;
  end

  always_comb begin
    case (sel)
      SRC_NFS: data_o = NEG_FS;
      SRC_PRN: data_o = prn_i;
      default: data_o = adc_data_i;
    endcase
  end
endmodule

// File: rtl/adc_test_src.sv
module adc_test_src #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] adc_data_i,
  input  logic         en_i,
  input  logic         test_en_i,
  input  logic         prn_sel_i,
  input  logic         ab_emul_i,
  output logic [W-1:0] data_o,
  output logic         en_o
);
  logic [W-1:0] prn;
  logic         emul;
  logic         phase;

  assign emul = test_en_i & ab_emul_i;

  adc_test_src_prn #(.W(W)) u_prn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prn_o  (prn)
  );

  adc_test_src_abgen u_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .emul_i  (emul),
    .phase_o (phase)
  );

  adc_test_src_mux #(.W(W)) u_mux (
    .test_en_i  (test_en_i),
    .prn_sel_i  (prn_sel_i),
    .adc_data_i (adc_data_i),
    .prn_i      (prn),
    .data_o     (data_o)
  );

  assign en_o = emul ? phase : en_i;
endmodule

// File: rtl/adc_test_src_chk.sv
module adc_test_src_chk #(
  parameter int W = 14
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] adc_data_i,
  input logic         en_i,
  input logic         test_en_i,
  input logic         prn_sel_i,
  input logic         ab_emul_i,
  input logic [W-1:0] data_o,
  input logic         en_o
);
  localparam logic [W-1:0] NEG_FS = {1'b1, {(W-1){1'b0}}};

  logic emul;
  logic seen_q;

  assign emul = test_en_i & ab_emul_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_live_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |-> data_o == adc_data_i);

  p_neg_fs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && !prn_sel_i) |-> data_o == NEG_FS);

  p_prn_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && prn_sel_i) |-> data_o != '0);

  p_en_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emul |-> en_o == en_i);

  p_ab_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && emul && $past(emul)) |-> en_o != $past(en_o));

  p_ab_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && emul && !$past(emul)) |-> en_o);
endmodule

bind adc_test_src adc_test_src_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adc_data_i (adc_data_i),
  .en_i       (en_i),
  .test_en_i  (test_en_i),
  .prn_sel_i  (prn_sel_i),
  .ab_emul_i  (ab_emul_i),
  .data_o     (data_o),
  .en_o       (en_o)
);

// File: tb/adc_test_src_test.sv
`timescale 1ns/1ps
module adc_test_src_test;
  localparam int W = 14;
  localparam int PERIOD = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] adc_data = '0;
  logic         en_pin = 1'b0;
  logic         test_en = 1'b0;
  logic         prn_sel = 1'b0;
  logic         ab_emul = 1'b0;
  logic [W-1:0] data_o;
  logic         en_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_test_src #(.W(W)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .adc_data_i (adc_data),
    .en_i       (en_pin),
    .test_en_i  (test_en),
    .prn_sel_i  (prn_sel),
    .ab_emul_i  (ab_emul),
    .data_o     (data_o),
    .en_o       (en_o)
  );

  // behavioural reference
  int unsigned m_prn;
  bit          m_phase;
  bit          m_prev_emul;

  function automatic int unsigned prn_next(input int unsigned s);
    int unsigned b;
    b = ((s >> 13) ^ (s >> 4) ^ (s >> 2) ^ s) & 1;
    return ((s << 1) | b) & 32'h3FFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prn       <= 32'h3FFF;
      m_phase     <= 1'b1;
      m_prev_emul <= 1'b0;
    end else begin
      m_prn       <= prn_next(m_prn);
      m_phase     <= (test_en && ab_emul) ? !m_phase : 1'b1;
      m_prev_emul <= test_en && ab_emul;
    end
  end

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    int unsigned exp_d;
    bit          emul;
    string       dtag;
    string       etag;
    emul = test_en && ab_emul;
    if (!rst_n) begin
      dtag = "R8"; etag = "R8";
    end else begin
      dtag = !test_en ? "R1" : (prn_sel ? "R3" : "R2");
      etag = !emul ? "R5" : (m_prev_emul ? "R6" : "R7");
    end
    if (!test_en)     exp_d = adc_data;
    else if (prn_sel) exp_d = m_prn;
    else              exp_d = 32'h2000;
    check(dtag, data_o, exp_d);
    check(etag, en_o, emul ? m_phase : en_pin);
    if (test_en && prn_sel) check("R4", (data_o != 0), 1);
  end

  task automatic run(input bit t, input bit p, input bit a, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      test_en  = t;
      prn_sel  = p;
      ab_emul  = a;
      adc_data = W'($urandom);
      en_pin   = 1'($urandom);
    end
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state with PRN and emulation selected
    test_en = 1'b1; prn_sel = 1'b1; ab_emul = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R8", data_o, 32'h3FFF);
    check("R8", en_o, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // first post-reset cycle still shows the seed, phase opens at 1 (R8, R7)
    #2;
    check("R8", data_o, 32'h3FFF);
    check("R7", en_o, 1);

    run(1, 1, 1, 20);   // PRN with A/B toggling (R3, R6)
    run(0, 1, 1, 20);   // live data, emulation bit ignored (R1, R5)
    run(1, 0, 0, 10);   // negative full scale (R2)
    run(1, 0, 1, 7);    // re-entry of emulation (R7)
    run(1, 1, 0, 5);    // leave emulation (R5)
    run(1, 1, 1, 3);    // re-enter (R7)
    run(0, 0, 0, 10);
    for (int k = 0; k < 40; k++)
      run(1'($urandom), 1'($urandom), 1'($urandom), 1 + ($urandom % 4));

    // full generator period from reset (R4)
    @(posedge clk); #1;
    rst_n = 1'b0; test_en = 1'b1; prn_sel = 1'b1; ab_emul = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (PERIOD - 1) @(posedge clk);
    #2;
    check("R4", (data_o == 14'h3FFF), 0);
    @(posedge clk); #2;
    check("R4", data_o, 32'h3FFF);

    run(0, 0, 0, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule